// File: doc/BRIEF.md
# ROM Settings Streaming Engine

This block reprograms one channel by copying a list of setting words out of a ROM into that channel's settings store. The host reaches it through a small register set: a channel select, a control/status word with a 2-bit mode field, and an indirect window. The window has an index register and a staging data register. A commit trigger writes the staged data into one of two internal slots. Slot 0 holds the ROM start address. Slot 1 holds an arm flag.

When a commit leaves the arm flag set while streaming mode is selected, the engine takes a snapshot of the channel select. It then reads the ROM one entry at a time, starting at the start address. Each entry is a 32-bit word: the low half names a setting offset and the high half carries the value. For each entry the engine issues a write request to the target and waits for the acknowledge before it fetches the next entry. An entry whose offset is all ones ends the list.

Busy is the only sign that the stream has finished. If no end entry appears within a parameterised number of entries, the run stops and a sticky error is raised.

Top module: `stream_engine`

## Requirements
- R1: After reset, busy, the error flag, the ROM read enable and the target request are 0. Every host register reads 0, including the slot readback.
- R2: The host registers are at these addresses and read back what was written.
  - Address 0: channel select, bits CW-1:0.
  - Address 1: control/status. Bits 1:0 hold the mode. Bit 2 is a write-only commit trigger. Bit 3 is a write-only error clear. Bit 8 reads busy. Bit 9 reads the error flag.
  - Address 2: window index, bit 0.
  - Address 3: staging data, 32 bits.
  - Address 4: read-only view of the slot chosen by the window index. Slot 0 reads the start address, zero-extended. Slot 1 reads the arm flag in bit 0.
- R3: A commit while idle copies the staging data into the slot chosen by the window index. With index 0, bits AW-1:0 become the ROM start address.
- R4: A commit while idle starts a stream when two things both hold. The mode bits written in that same control write are 2'b00. The arm flag, after the commit, is 1. Busy reads 1 from the cycle after the commit.
- R5: The engine reads ROM entries at start, start+1, and so on (modulo 2^AW). It pulses the ROM read enable for one cycle and takes the data in the following cycle. For each non-end entry it raises a request carrying the snapshot channel, offset = entry[15:0] and value = entry[31:16]. The request and its fields are held until acknowledged. No ROM read occurs while a request is pending.
- R6: An entry with offset 16'hFFFF is not written to the target. It ends the stream: busy falls and the arm flag clears.
- R7: A commit whose control write carries a mode other than 2'b00 updates the internal slot but starts no stream and issues no ROM read.
- R8: After MAX_ENTRIES entries have been written, a further entry that is not an end entry is not written. The stream ends, the arm flag clears and the error flag is set. The error flag stays set across later streams until a control write with bit 3 = 1.
- R9: The channel used for a stream is the channel select value at the moment the stream starts. Writes to the channel select during the stream do not change it.
- R10: A commit while busy is ignored. It changes no slot and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational from reg_addr) |
| rom_en | output | 1 | ROM read enable, one cycle per entry |
| rom_addr | output | AW | ROM read address |
| rom_data | input | 32 | ROM data, valid the cycle after rom_en |
| tgt_req | output | 1 | Setting write request to the target |
| tgt_chan | output | CW | Channel being reprogrammed |
| tgt_offset | output | 16 | Setting offset |
| tgt_value | output | 16 | Setting value |
| tgt_ack | input | 1 | Target acknowledge of the pending request |
| busy | output | 1 | Stream in progress |

## Verification
The hardest situations to reach are the two that need a long run. The first is the entry-limit stop, which needs a ROM window with no end entry in its first MAX_ENTRIES+1 words. The second is host activity during a stream, which needs the stream to last long enough for several register writes to land while busy is high. The bench fills the ROM with random words whose offsets avoid the end value, then places the end entry at a chosen distance from a random start: zero, exactly MAX_ENTRIES, or never. A target model that answers after random delays stretches the stream, so that channel changes and commits can be issued while busy is high. Afterwards the bench reads back the slots and the recorded target writes.

// File: rtl/stream_engine.sv
module stream_engine #(
  parameter int CW          = 4,
  parameter int AW          = 8,
  parameter int MAX_ENTRIES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          rom_en,
  output logic [AW-1:0] rom_addr,
  input  logic [31:0]   rom_data,
  output logic          tgt_req,
  output logic [CW-1:0] tgt_chan,
  output logic [15:0]   tgt_offset,
  output logic [15:0]   tgt_value,
  input  logic          tgt_ack,
  output logic          busy
);
  localparam int          NW       = $clog2(MAX_ENTRIES + 1);
  localparam logic [15:0] END_MARK = 16'hFFFF;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LATCH, S_WRITE} st_t;

  st_t            st_q;
  logic [CW-1:0]  chan_q, run_chan_q;
  logic [1:0]     mode_q;
  logic           widx_q;
  logic [31:0]    wdat_q;
  logic [AW-1:0]  base_q;
  logic           arm_q, err_q;
  logic [NW-1:0]  cnt_q;
  logic [31:0]    ent_q;

  logic wr_ctrl, go, arm_nx, start, is_end, over;

  assign wr_ctrl = reg_we && reg_addr == 3'd1;
  assign go      = wr_ctrl && reg_wdata[2] && st_q == S_IDLE;
  assign arm_nx  = widx_q ? wdat_q[0] : arm_q;
  assign start   = go && reg_wdata[1:0] == 2'b00 && arm_nx;
  assign is_end  = rom_data[15:0] == END_MARK;
  assign over    = cnt_q == NW'(MAX_ENTRIES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      chan_q     <= '0;
      run_chan_q <= '0;
      mode_q     <= '0;
      widx_q     <= 1'b0;
      wdat_q     <= '0;
      base_q     <= '0;
      arm_q      <= 1'b0;
      err_q      <= 1'b0;
      cnt_q      <= '0;
      ent_q      <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0:    chan_q <= reg_wdata[CW-1:0];
          3'd1:    mode_q <= reg_wdata[1:0];
          3'd2:    widx_q <= reg_wdata[0];
          3'd3:    wdat_q <= reg_wdata;
          default: ;
        endcase
      end
      if (go) begin
        if (!widx_q) base_q <= wdat_q[AW-1:0];
        else         arm_q  <= wdat_q[0];
      end
      if (wr_ctrl && reg_wdata[3]) err_q <= 1'b0;

      case (st_q)
        S_IDLE: if (start) begin
          st_q       <= S_FETCH;
          cnt_q      <= '0;
          run_chan_q <= chan_q;
        end
        S_FETCH: st_q <= S_LATCH;
        S_LATCH: begin
          if (is_end) begin
            st_q  <= S_IDLE;
            arm_q <= 1'b0;
          end else if (over) begin
            st_q  <= S_IDLE;
            arm_q <= 1'b0;
            err_q <= 1'b1;
          end else begin
            ent_q <= rom_data;
            st_q  <= S_WRITE;
          end
        end
        S_WRITE: if (tgt_ack) begin
          cnt_q <= cnt_q + 1'b1;
          st_q  <= S_FETCH;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = st_q != S_IDLE;
  assign rom_en     = st_q == S_FETCH;
  assign rom_addr   = base_q + AW'(cnt_q);
  assign tgt_req    = st_q == S_WRITE;
  assign tgt_chan   = run_chan_q;
  assign tgt_offset = ent_q[15:0];
  assign tgt_value  = ent_q[31:16];

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(chan_q);
      3'd1:    reg_rdata = {22'b0, err_q, busy, 6'b0, mode_q};
      3'd2:    reg_rdata = {31'b0, widx_q};
      3'd3:    reg_rdata = wdat_q;
      3'd4:    reg_rdata = widx_q ? {31'b0, arm_q} : 32'(base_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/stream_engine_chk.sv
module stream_engine_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          err,
  input logic          arm,
  input logic          rom_en,
  input logic          tgt_req,
  input logic          tgt_ack,
  input logic [15:0]   tgt_offset,
  input logic [15:0]   tgt_value,
  input logic [CW-1:0] tgt_chan
);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && !tgt_ack |=> tgt_req && $stable(tgt_offset) && $stable(tgt_value));
  p_no_fetch_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> !rom_en);
  p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> !rom_en);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tgt_req && !rom_en);
  p_end_not_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> tgt_offset != 16'hFFFF);
  p_arm_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !arm);
  p_err_at_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
  p_chan_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(tgt_chan));
endmodule

bind stream_engine stream_engine_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err_q), .arm(arm_q),
  .rom_en(rom_en), .tgt_req(tgt_req), .tgt_ack(tgt_ack),
  .tgt_offset(tgt_offset), .tgt_value(tgt_value), .tgt_chan(tgt_chan)
);

// File: tb/tb_stream_engine.sv
`timescale 1ns/1ps
module tb_stream_engine;
  localparam int CW = 4, AW = 8, MAXE = 16;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic rom_en; logic [AW-1:0] rom_addr; logic [31:0] rom_data = 0;
  logic tgt_req; logic [CW-1:0] tgt_chan; logic [15:0] tgt_offset, tgt_value;
  logic tgt_ack = 0; logic busy;

  stream_engine #(.CW(CW), .AW(AW), .MAX_ENTRIES(MAXE)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] rom [256];
  logic [15:0] rec_off [64], rec_val [64];
  logic [CW-1:0] rec_chan [64];
  int rec_n = 0, fetch_n = 0, addr_err = 0, ack_max = 0, ack_cur = 0, ack_wait = 0;
  logic [7:0] cur_base = 0;
  bit m_err = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  // ROM and target models, plus fetch order monitor
  initial forever begin
    @(negedge clk);
    if (rom_en) begin
      rom_data = rom[rom_addr];
      if (rom_addr !== cur_base + 8'(fetch_n)) addr_err++;
      fetch_n++;
    end
    if (rom_en && tgt_req) addr_err++;
    if (tgt_ack) tgt_ack = 0;
    else if (tgt_req) begin
      if (ack_wait >= ack_cur) begin
        tgt_ack = 1;
        if (rec_n < 64) begin
          rec_off[rec_n] = tgt_offset; rec_val[rec_n] = tgt_value; rec_chan[rec_n] = tgt_chan;
        end
        rec_n++;
        ack_wait = 0;
        ack_cur = $urandom_range(ack_max, 0);
      end else ack_wait++;
    end
  end

  task automatic fill(logic [7:0] base, int len);
    for (int i = 0; i < 256; i++) begin
      logic [31:0] w = $urandom;
      if (w[15:0] == 16'hFFFF) w[15:0] = 16'hFFFE;
      rom[i] = w;
    end
    if (len <= MAXE) rom[8'(base + 8'(len))][15:0] = 16'hFFFF;
  endtask

  function automatic int walk(logic [7:0] base, output bit e);
    e = 0;
    for (int i = 0; i <= MAXE; i++) begin
      if (rom[8'(base + 8'(i))][15:0] == 16'hFFFF) return i;
      if (i == MAXE) begin e = 1; return MAXE; end
    end
    return 0;
  endfunction

  task automatic stream(logic [7:0] base, logic [CW-1:0] ch, bit meddle);
    logic [31:0] v; bit e; int n, bad, t;
    n = walk(base, e);
    wr(0, 32'(ch)); wr(2, 0); wr(3, 32'(base)); wr(1, 32'h4);
    wr(2, 1); wr(3, 1);
    rec_n = 0; fetch_n = 0; addr_err = 0; cur_base = base;
    ack_cur = $urandom_range(ack_max, 0); ack_wait = 0;
    wr(1, 32'h4);
    rd(1, v);
    chk(v[8] == 1'b1, "R4", "busy after arm+commit", 32'(v[8]), 1);
    if (meddle) begin
      wr(0, 32'(~ch)); wr(2, 0); wr(3, 32'h77); wr(1, 32'h4);
      rd(1, v);
      chk(v[8] == 1'b1, "R10", "still busy during host commit", 32'(v[8]), 1);
    end
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    chk(!busy, "R6", "stream completes", 32'(busy), 0);
    chk(rec_n == n, "R5", "target write count", 32'(rec_n), 32'(n));
    chk(fetch_n == n + 1, "R5", "ROM read count", 32'(fetch_n), 32'(n + 1));
    chk(addr_err == 0, "R5", "ROM order / read during request", 32'(addr_err), 0);
    bad = 0;
    for (int k = 0; k < n && k < 64; k++) begin
      logic [31:0] w = rom[8'(base + 8'(k))];
      if (rec_off[k] !== w[15:0] || rec_val[k] !== w[31:16]) bad++;
      if (rec_chan[k] !== ch) bad++;
    end
    chk(bad == 0, meddle ? "R9" : "R5", "entry/channel mismatches", 32'(bad), 0);
    m_err = m_err | e;
    rd(1, v);
    chk(v[9] == m_err, "R8", "error flag", 32'(v[9]), 32'(m_err));
    if (meddle) begin
      wr(2, 0); rd(4, v);
      chk(v == 32'(base), "R10", "start slot unchanged by busy commit", v, 32'(base));
    end
    wr(2, 1); rd(4, v);
    chk(v == 0, "R6", "arm flag cleared", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) rom[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk(!busy && !rom_en && !tgt_req, "R1", "idle outputs", {busy, rom_en, tgt_req}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1", "register reset value", v, 0);
    end
    // R2
    wr(0, 32'hFFFF_FFF9); rd(0, v); chk(v == 32'h9, "R2", "channel readback", v, 32'h9);
    wr(1, 32'h3);         rd(1, v); chk(v == 32'h3, "R2", "mode readback", v, 32'h3);
    wr(2, 32'h1);         rd(2, v); chk(v == 32'h1, "R2", "index readback", v, 32'h1);
    wr(3, 32'hDEAD_BEEF); rd(3, v); chk(v == 32'hDEADBEEF, "R2", "staging readback", v, 32'hDEADBEEF);
    // R3: commit start address without arm
    wr(2, 0); wr(3, 32'h1A5); wr(1, 32'h4);
    rd(4, v); chk(v == 32'hA5, "R3", "start address slot", v, 32'hA5);
    rd(1, v); chk(v[8] == 0, "R4", "no start without arm", 32'(v[8]), 0);
    // R7: armed commit in non-streaming mode
    fetch_n = 0;
    wr(2, 1); wr(3, 1); wr(1, 32'h5);
    repeat (6) @(negedge clk);
    chk(!busy && fetch_n == 0, "R7", "no stream in mode 01", 32'(fetch_n) | 32'(busy), 0);
    rd(4, v); chk(v == 1, "R7", "arm slot still written", v, 1);
    wr(3, 0); wr(1, 32'h6);
    rd(4, v); chk(v == 0, "R7", "arm slot cleared via mode 10 commit", v, 0);
    rd(1, v); chk(v[8] == 0, "R7", "still idle", 32'(v[8]), 0);
    // directed lengths
    ack_max = 0; fill(8'h10, 0);     stream(8'h10, 4'h2, 0);
    ack_max = 2; fill(8'hF8, MAXE);  stream(8'hF8, 4'h5, 0);
    ack_max = 1; fill(8'h40, MAXE + 1); stream(8'h40, 4'h7, 0);
    // R8 sticky then clear
    ack_max = 1; fill(8'h22, 3); stream(8'h22, 4'h1, 0);
    wr(1, 32'h8); m_err = 0;
    rd(1, v); chk(v[9] == 0, "R8", "error cleared by bit 3", 32'(v[9]), 0);
    // R9 / R10 activity during stream
    ack_max = 3; fill(8'h80, 12); stream(8'h80, 4'hA, 1);
    // random streams
    for (int it = 0; it < 24; it++) begin
      logic [7:0] b = 8'($urandom);
      int len = $urandom_range(MAXE + 3, 0);
      ack_max = $urandom_range(3, 0);
      fill(b, len);
      stream(b, CW'($urandom), it % 5 == 4);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule